// File: doc/BRIEF.md
# Transmit Descriptor Queue Engine

This block runs the transmit side of a DMA for an Ethernet MAC. Software places a ring of two-word descriptors in memory. The first word holds a buffer's byte address. The second word holds that buffer's length, its flags and the status fields. Software loads the ring start through a queue-pointer write and then raises the transmit enable.

The engine fetches descriptors one at a time and checks the ownership flag in each. Each usable buffer is offered to the frame transmitter with its address, length, CRC-suppress option and end-of-frame flag. A frame may be gathered from as many as `MAX_BUFS` buffers. When the transmitter reports that the frame has gone, the engine writes one status word back to the frame's first descriptor. That word sets the ownership flag and carries the transmitter's error code.

Padding short frames to 64 bytes and generating the CRC belong to the transmitter. The engine only passes on the per-buffer CRC option. It stops when it meets a descriptor that software still has to process, or when a frame holds too many buffers. It stays stopped until the enable is taken away.

Top module: `txq_engine`

## Requirements
- R1: After reset, mem_req, buf_valid, frame_done, used_stop, overlong_abort and irq are all low.
- R2: A queue-pointer write sets both the ring start and the current descriptor to the written byte address. The next fetch reads word 0 at that address and then word 1 at that address plus 4.
- R3: Word 1 fields are: bit 31 owned-by-software (used), bit 30 wrap, bit 16 no-CRC, bit 15 last buffer, bits 10:0 length. Each usable descriptor is offered once on buf_addr, buf_len, buf_nocrc and buf_last. Length 0 is offered like any other length.
- R4: A word 1 read with bit 31 set offers no buffer from that descriptor. It raises used_stop and irq for one cycle each.
- R5: After a used stop, the engine makes no memory request while tx_en stays high. It leaves the current pointer on the used descriptor, so disabling and re-enabling resumes from that descriptor.
- R6: After each accepted buffer the pointer steps by 8 bytes. If the descriptor had its wrap bit set, the pointer returns to the ring start instead.
- R7: After 1024 consecutive descriptors without a wrap bit, the pointer returns to the ring start.
- R8: After the last buffer of a frame, the engine waits for tx_done. It then writes exactly one word, to word 1 of the frame's first descriptor. That word is bit 31 set, bit 30 copied from that descriptor, bits 29:27 = tx_err, and bits 26:0 copied from that descriptor. Word 1 of the frame's other descriptors is left unchanged. frame_done pulses when the write is accepted.
- R9: Reading a buffer descriptor beyond MAX_BUFS (128) in one frame with no last flag seen causes these effects:
  - the frame is aborted;
  - overlong_abort and irq pulse;
  - no write-back is made;
  - the engine halts as in R5.
- R10: While idle with tx_en low, no memory request is made. tx_en is sampled only between frames.
- R11: A memory request keeps mem_req, mem_addr, mem_we and mem_wdata stable until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| qptr_wr | input | 1 | Queue-pointer write strobe |
| qptr_data | input | ADDR_W | Ring start byte address |
| tx_en | input | 1 | Transmit enable |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| buf_valid | output | 1 | Buffer offered to transmitter |
| buf_ready | input | 1 | Transmitter takes the buffer |
| buf_addr | output | ADDR_W | Buffer byte address |
| buf_len | output | LEN_W | Buffer length in bytes |
| buf_nocrc | output | 1 | Send frame without automatic CRC |
| buf_last | output | 1 | Final buffer of the frame |
| tx_done | input | 1 | Transmitter finished the frame |
| tx_err | input | 3 | Transmit error code for the frame |
| frame_done | output | 1 | Status write-back completed (pulse) |
| used_stop | output | 1 | Stopped on a used descriptor (pulse) |
| overlong_abort | output | 1 | Frame exceeded buffer limit (pulse) |
| irq | output | 1 | Interrupt pulse on either stop cause |

## Verification
The assertions assume certain input behaviour:
- The memory answers each request once, with a single-cycle mem_ack.
- The transmitter raises tx_done only after it has taken a last buffer.
- qptr_wr arrives only while the engine is idle or halted with tx_en low.

The bench memory and transmitter models hold to each of these points. Between tests the bench drops tx_en and waits for the engine to settle before it writes a new ring start. Memory latency alternates between zero and one wait cycle, so the request-hold rule is exercised under both.

// File: rtl/txq_pkg.sv
package txq_pkg;
   localparam int unsigned TXQ_WORD_W    = 32;
   localparam int unsigned TXQ_USED_BIT  = 31;
   localparam int unsigned TXQ_WRAP_BIT  = 30;
   localparam int unsigned TXQ_ERR_W     = 3;
   localparam int unsigned TXQ_NOCRC_BIT = 16;
   localparam int unsigned TXQ_LAST_BIT  = 15;
   localparam int unsigned TXQ_CTRL_OFS  = 4;
   localparam int unsigned TXQ_STRIDE    = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GET_ADDR,
      ST_GET_CTRL,
      ST_OFFER,
      ST_WAIT_TX,
      ST_WRITEBACK,
      ST_HALT
   } txq_state_e;
endpackage

// File: rtl/txq_ring_ptr.sv
module txq_ring_ptr #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned STRIDE   = 8,
   parameter int unsigned RING_MAX = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   input  logic              wrap_req,
   output logic [ADDR_W-1:0] cur_addr
);
   localparam int unsigned IDX_W = (RING_MAX > 1) ? $clog2(RING_MAX) : 1;

   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] cur_q;
   logic              at_end;
   logic              go_base;

   initial begin : param_chk
      assert (STRIDE > 0 && STRIDE < (1 << 16)) else $fatal(1, "STRIDE out of range");
   end

   generate
      if (RING_MAX > 0) begin : g_count_wrap
         logic [IDX_W-1:0] idx_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               idx_q <= '0;
            end else if (load) begin
               idx_q <= '0;
            end else if (step) begin
               idx_q <= go_base ? '0 : idx_q + 1'b1;
            end
         end
         assign at_end = (idx_q == IDX_W'(RING_MAX - 1));
      end else begin : g_flag_wrap
         assign at_end = 1'b0;
      end
   endgenerate

   assign go_base = wrap_req || at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cur_q  <= '0;
      end else if (load) begin
         base_q <= load_addr;
         cur_q  <= load_addr;
      end else if (step) begin
         cur_q <= go_base ? base_q : cur_q + ADDR_W'(STRIDE);
      end
   end

   assign cur_addr = cur_q;

   assert_step_stride_R6: assert property (@(posedge clk) disable iff (!rst_n)
      step && !load && !go_base |=> cur_q == $past(cur_q) + ADDR_W'(STRIDE));
   assert_step_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
      step && !load && go_base |=> cur_q == base_q);
endmodule

// File: rtl/txq_buf_count.sv
module txq_buf_count #(
   parameter int unsigned MAX_BUFS = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic incr,
   output logic empty,
   output logic full
);
   localparam int unsigned CNT_W = $clog2(MAX_BUFS + 1);

   logic [CNT_W-1:0] cnt_q;

   initial begin : param_chk
      assert (MAX_BUFS >= 1) else $fatal(1, "MAX_BUFS must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (incr) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CNT_W'(MAX_BUFS));

   assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      incr && !clear |-> !full);
endmodule

// File: rtl/txq_engine.sv
module txq_engine
   import txq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned LEN_W    = 11,
   parameter int unsigned MAX_BUFS = 128,
   parameter int unsigned RING_MAX = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              qptr_wr,
   input  logic [ADDR_W-1:0] qptr_data,
   input  logic              tx_en,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              buf_valid,
   input  logic              buf_ready,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [LEN_W-1:0]  buf_len,
   output logic              buf_nocrc,
   output logic              buf_last,
   input  logic              tx_done,
   input  logic [2:0]        tx_err,
   output logic              frame_done,
   output logic              used_stop,
   output logic              overlong_abort,
   output logic              irq
);
   localparam int unsigned KEEP_W = TXQ_WRAP_BIT - TXQ_ERR_W;

   initial begin : param_chk
      assert (ADDR_W >= 8 && ADDR_W <= TXQ_WORD_W) else $fatal(1, "ADDR_W out of range");
      assert (LEN_W >= 1 && LEN_W <= TXQ_LAST_BIT) else $fatal(1, "LEN_W overlaps flags");
   end

   txq_state_e state_q;
   logic [ADDR_W-1:0] cur_addr;
   logic [ADDR_W-1:0] first_ptr_q;
   logic [ADDR_W-1:0] bufaddr_q;
   logic [LEN_W-1:0]  len_q;
   logic              nocrc_q, last_q, wrap_q;
   logic              first_wrap_q;
   logic [KEEP_W-1:0] first_keep_q;
   logic [2:0]        err_q;
   logic              used_q, over_q, irq_q, done_q;
   logic              take_buf, cnt_clear, cnt_empty, cnt_full;

   assign take_buf  = (state_q == ST_OFFER) && buf_ready;
   assign cnt_clear = (state_q == ST_HALT) ||
                      ((state_q == ST_WRITEBACK) && mem_ack);

   txq_ring_ptr #(
      .ADDR_W  (ADDR_W),
      .STRIDE  (TXQ_STRIDE),
      .RING_MAX(RING_MAX)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (qptr_wr),
      .load_addr(qptr_data),
      .step     (take_buf),
      .wrap_req (wrap_q),
      .cur_addr (cur_addr)
   );

   txq_buf_count #(
      .MAX_BUFS(MAX_BUFS)
   ) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(cnt_clear),
      .incr (take_buf),
      .empty(cnt_empty),
      .full (cnt_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         first_ptr_q  <= '0;
         bufaddr_q    <= '0;
         len_q        <= '0;
         nocrc_q      <= 1'b0;
         last_q       <= 1'b0;
         wrap_q       <= 1'b0;
         first_wrap_q <= 1'b0;
         first_keep_q <= '0;
         err_q        <= '0;
         used_q       <= 1'b0;
         over_q       <= 1'b0;
         irq_q        <= 1'b0;
         done_q       <= 1'b0;
      end else begin
         used_q <= 1'b0;
         over_q <= 1'b0;
         irq_q  <= 1'b0;
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (tx_en) state_q <= ST_GET_ADDR;
            end
            ST_GET_ADDR: begin
               if (mem_ack) begin
                  bufaddr_q <= mem_rdata[ADDR_W-1:0];
                  if (cnt_empty) first_ptr_q <= cur_addr;
                  state_q <= ST_GET_CTRL;
               end
            end
            ST_GET_CTRL: begin
               if (mem_ack) begin
                  len_q   <= mem_rdata[LEN_W-1:0];
                  nocrc_q <= mem_rdata[TXQ_NOCRC_BIT];
                  last_q  <= mem_rdata[TXQ_LAST_BIT];
                  wrap_q  <= mem_rdata[TXQ_WRAP_BIT];
                  if (mem_rdata[TXQ_USED_BIT]) begin
                     used_q  <= 1'b1;
                     irq_q   <= 1'b1;
                     state_q <= ST_HALT;
                  end else if (cnt_full) begin
                     over_q  <= 1'b1;
                     irq_q   <= 1'b1;
                     state_q <= ST_HALT;
                  end else begin
                     if (cnt_empty) begin
                        first_wrap_q <= mem_rdata[TXQ_WRAP_BIT];
                        first_keep_q <= mem_rdata[KEEP_W-1:0];
                     end
                     state_q <= ST_OFFER;
                  end
               end
            end
            ST_OFFER: begin
               if (buf_ready) state_q <= last_q ? ST_WAIT_TX : ST_GET_ADDR;
            end
            ST_WAIT_TX: begin
               if (tx_done) begin
                  err_q   <= tx_err;
                  state_q <= ST_WRITEBACK;
               end
            end
            ST_WRITEBACK: begin
               if (mem_ack) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_HALT: begin
               if (!tx_en) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = cur_addr;
      unique case (state_q)
         ST_GET_ADDR:  mem_req = 1'b1;
         ST_GET_CTRL: begin
            mem_req  = 1'b1;
            mem_addr = cur_addr + ADDR_W'(TXQ_CTRL_OFS);
         end
         ST_WRITEBACK: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = first_ptr_q + ADDR_W'(TXQ_CTRL_OFS);
         end
         default: ;
      endcase
   end

   assign mem_wdata      = {1'b1, first_wrap_q, err_q, first_keep_q};
   assign buf_valid      = (state_q == ST_OFFER);
   assign buf_addr       = bufaddr_q;
   assign buf_len        = len_q;
   assign buf_nocrc      = nocrc_q;
   assign buf_last       = last_q;
   assign frame_done     = done_q;
   assign used_stop      = used_q;
   assign overlong_abort = over_q;
   assign irq            = irq_q;

   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack && !qptr_wr |=> mem_req && $stable(mem_addr) && $stable(mem_we)
      && $stable(mem_wdata));
   assert_offer_unused_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_valid) |-> !$past(mem_rdata[TXQ_USED_BIT]) && $past(mem_ack));
   assert_stop_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(used_stop && overlong_abort));
   assert_halt_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (used_stop || overlong_abort) |-> !mem_req);
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) && !tx_en |=> !mem_req);
   assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $past(mem_req && mem_we && mem_ack));
endmodule

// File: tb/txq_engine_test.sv
module txq_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        qptr_wr = 1'b0;
   logic [31:0] qptr_data = '0;
   logic        tx_en = 1'b0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        buf_valid;
   logic        buf_ready = 1'b0;
   logic [31:0] buf_addr;
   logic [10:0] buf_len;
   logic        buf_nocrc, buf_last;
   logic        tx_done = 1'b0;
   logic [2:0]  tx_err = '0;
   logic        frame_done, used_stop, overlong_abort, irq;

   always #2.5 clk = ~clk;

   txq_engine uut (
      .clk(clk), .rst_n(rst_n), .qptr_wr(qptr_wr), .qptr_data(qptr_data), .tx_en(tx_en),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .buf_valid(buf_valid), .buf_ready(buf_ready),
      .buf_addr(buf_addr), .buf_len(buf_len), .buf_nocrc(buf_nocrc), .buf_last(buf_last),
      .tx_done(tx_done), .tx_err(tx_err), .frame_done(frame_done), .used_stop(used_stop),
      .overlong_abort(overlong_abort), .irq(irq)
   );

   bit [31:0] mem [int unsigned];
   int n_tests = 0, n_fail = 0;
   int n_reads = 0, n_writes = 0, n_used = 0, n_over = 0, n_irq = 0, n_done = 0;
   int n_frames_tx = 0, hold_bad = 0, req_cycles = 0, n_bufs = 0;
   bit [31:0] last_rd_addr = '0, first_rd [$];
   bit [31:0] q_addr [$];
   int        q_len [$];
   bit        q_nocrc [$], q_last [$];
   bit        finished = 1'b0;

   task automatic chk(string req, bit [31:0] act, bit [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit [31:0] mk_ctrl(bit used, bit wrap, bit last, bit nocrc, int len);
      return (32'(used) << 31) | (32'(wrap) << 30) | (32'(nocrc) << 16) |
             (32'(last) << 15) | (32'(len) & 32'h7FF);
   endfunction

   function automatic bit [2:0] err_for(int idx);
      return 3'((idx * 5) % 8);
   endfunction

   task automatic put_desc(bit [31:0] at, bit [31:0] ba, bit [31:0] ctrl);
      mem[at] = ba;
      mem[at + 4] = ctrl;
   endtask

   // memory responder: alternating zero / one wait cycle
   initial begin
      bit [31:0] prev_addr = '0;
      bit        prev_pend = 1'b0;
      int        lat = 0, waited = 0;
      forever begin
         @(negedge clk);
         if (prev_pend && !(mem_req && mem_addr == prev_addr)) hold_bad++;
         if (mem_req) req_cycles++;
         if (mem_ack) begin
            mem_ack = 1'b0;
            prev_pend = 1'b0;
         end else if (mem_req) begin
            if (waited >= lat) begin
               mem_ack = 1'b1;
               if (mem_we) begin
                  mem[mem_addr] = mem_wdata;
                  n_writes++;
               end else begin
                  mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                  n_reads++;
                  last_rd_addr = mem_addr;
                  first_rd.push_back(mem_addr);
               end
               waited = 0;
               lat = 1 - lat;
               prev_pend = 1'b0;
            end else begin
               waited++;
               prev_pend = 1'b1;
               prev_addr = mem_addr;
            end
         end
      end
   end

   // transmitter model
   initial begin
      int cd = 0;
      forever begin
         @(negedge clk);
         tx_done = 1'b0;
         if (cd > 0) begin
            cd--;
            if (cd == 0) begin
               tx_done = 1'b1;
               tx_err = err_for(n_frames_tx);
               n_frames_tx++;
            end
         end
         if (buf_ready) begin
            buf_ready = 1'b0;
         end else if (buf_valid) begin
            buf_ready = 1'b1;
            n_bufs++;
            q_addr.push_back(buf_addr);
            q_len.push_back(int'(buf_len));
            q_nocrc.push_back(buf_nocrc);
            q_last.push_back(buf_last);
            if (buf_last) cd = 3;
         end
      end
   end

   // pulse monitor
   initial begin
      forever begin
         @(negedge clk);
         if (used_stop) n_used++;
         if (overlong_abort) n_over++;
         if (irq) n_irq++;
         if (frame_done) n_done++;
      end
   end

   task automatic wait_for(ref int cnt, input int target);
      for (int i = 0; i < 40000 && cnt < target; i++) @(negedge clk);
   endtask

   task automatic restart(bit [31:0] base);
      tx_en = 1'b0;
      repeat (4) @(negedge clk);
      qptr_data = base;
      qptr_wr = 1'b1;
      @(negedge clk);
      qptr_wr = 1'b0;
      q_addr.delete(); q_len.delete(); q_nocrc.delete(); q_last.delete();
      first_rd.delete();
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         chk("R11 request hold", 32'(hold_bad), 32'h0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int u0, d0, r0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset outputs", {26'h0, mem_req, buf_valid, frame_done, used_stop, overlong_abort, irq},
          32'h0);

      // R10: idle with enable low makes no requests
      repeat (50) @(negedge clk);
      chk("R10 no request while disabled", 32'(req_cycles), 32'h0);

      // R2 R3 R4 R8: single-buffer frame, three-buffer frame, then used descriptor
      put_desc(32'h1000, 32'hA000, mk_ctrl(0, 0, 1, 0, 60));
      put_desc(32'h1008, 32'hA100, mk_ctrl(0, 0, 0, 1, 0));
      put_desc(32'h1010, 32'hA200, mk_ctrl(0, 0, 0, 0, 100));
      put_desc(32'h1018, 32'hA300, mk_ctrl(0, 0, 1, 0, 2047));
      put_desc(32'h1020, 32'hEEEE, mk_ctrl(1, 0, 1, 0, 5));
      restart(32'h1000);
      tx_en = 1'b1;
      wait_for(n_used, 1);
      chk("R2 first fetch word0", first_rd[0], 32'h1000);
      chk("R2 first fetch word1", first_rd[1], 32'h1004);
      chk("R3 buffer count", 32'(q_addr.size()), 32'd4);
      chk("R3 buf0 addr", q_addr[0], 32'hA000);
      chk("R3 buf0 len", 32'(q_len[0]), 32'd60);
      chk("R3 buf0 last", 32'(q_last[0]), 32'd1);
      chk("R3 zero-length buf1 len", 32'(q_len[1]), 32'd0);
      chk("R3 buf1 nocrc", 32'(q_nocrc[1]), 32'd1);
      chk("R3 buf1 last", 32'(q_last[1]), 32'd0);
      chk("R3 buf3 len 2047", 32'(q_len[3]), 32'd2047);
      chk("R3 buf3 last", 32'(q_last[3]), 32'd1);
      chk("R8 frame_done count", 32'(n_done), 32'd2);
      chk("R8 writeback frame A", mem[32'h1004],
          32'h8000_0000 | (32'(err_for(0)) << 27) | mk_ctrl(0, 0, 1, 0, 60));
      chk("R8 writeback frame B first", mem[32'h100C],
          32'h8000_0000 | (32'(err_for(1)) << 27) | mk_ctrl(0, 0, 0, 1, 0));
      chk("R8 frame B middle untouched", mem[32'h1014], mk_ctrl(0, 0, 0, 0, 100));
      chk("R8 frame B last untouched", mem[32'h101C], mk_ctrl(0, 0, 1, 0, 2047));
      chk("R8 write count", 32'(n_writes), 32'd2);
      chk("R4 used_stop pulses", 32'(n_used), 32'd1);
      chk("R4 irq pulses", 32'(n_irq), 32'd1);
      chk("R4 no buffer from used desc", 32'(n_bufs), 32'd4);

      // R5: halted while enabled, then resume from the same descriptor
      r0 = n_reads;
      repeat (40) @(negedge clk);
      chk("R5 no fetch while halted", 32'(n_reads - r0), 32'h0);
      tx_en = 1'b0;
      repeat (3) @(negedge clk);
      put_desc(32'h1020, 32'hA400, mk_ctrl(0, 0, 1, 0, 7));
      put_desc(32'h1028, 32'h0, mk_ctrl(1, 0, 0, 0, 0));
      q_addr.delete(); q_len.delete(); q_nocrc.delete(); q_last.delete();
      tx_en = 1'b1;
      wait_for(n_used, 2);
      chk("R5 resume at used descriptor", q_addr.size() > 0 ? q_addr[0] : 32'hFFFF_FFFF,
          32'hA400);
      chk("R5 resumed frame written back", mem[32'h1024][31], 1'b1);

      // R6: wrap bit returns to the ring start
      put_desc(32'h2000, 32'hB000, mk_ctrl(0, 0, 1, 0, 10));
      put_desc(32'h2008, 32'hB100, mk_ctrl(0, 1, 1, 0, 20));
      put_desc(32'h2010, 32'hDEAD, mk_ctrl(0, 0, 1, 0, 30));
      restart(32'h2000);
      u0 = n_used;
      tx_en = 1'b1;
      wait_for(n_used, u0 + 1);
      chk("R6 buffers before wrap", 32'(q_addr.size()), 32'd2);
      chk("R6 stepped to next descriptor", q_addr[1], 32'hB100);
      chk("R6 wrapped back to start", last_rd_addr, 32'h2004);
      chk("R6 wrap bit kept in writeback", mem[32'h200C][30], 1'b1);

      // R9: too many buffers without a last flag
      for (int i = 0; i < 130; i++)
         put_desc(32'h4000 + 32'(i * 8), 32'hC000 + 32'(i), mk_ctrl(0, 0, 0, 0, 1));
      restart(32'h4000);
      u0 = n_used;
      d0 = n_done;
      tx_en = 1'b1;
      wait_for(n_over, 1);
      repeat (10) @(negedge clk);
      chk("R9 buffers offered", 32'(q_addr.size()), 32'd128);
      chk("R9 overlong pulse", 32'(n_over), 32'd1);
      chk("R9 no writeback", mem[32'h4004], mk_ctrl(0, 0, 0, 0, 1));
      chk("R9 no frame_done", 32'(n_done - d0), 32'd0);
      chk("R9 stopped on descriptor 129", last_rd_addr, 32'h4000 + 32'd128 * 8 + 4);
      chk("R9 not a used stop", 32'(n_used - u0), 32'd0);

      // R7: 1024 descriptors without wrap bit roll back to start
      for (int i = 0; i < 1024; i++)
         put_desc(32'h10000 + 32'(i * 8), 32'hD000 + 32'(i), mk_ctrl(0, 0, 1, 0, 64));
      restart(32'h10000);
      u0 = n_used;
      d0 = n_done;
      tx_en = 1'b1;
      wait_for(n_used, u0 + 1);
      chk("R7 frames before rollover", 32'(n_done - d0), 32'd1024);
      chk("R7 rolled back to ring start", last_rd_addr, 32'h10004);
      chk("R7 last buffer of ring", q_addr[1023], 32'hD000 + 32'd1023);

      tx_en = 1'b0;
      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule